// File: doc/BRIEF.md
# RxStatus Interrupt Status Register

This block is the interrupt status register that sits next to a hardware poller of a receiver's status word on the display data channel. The poller reports six kinds of result. A message-size sample carries a 10-bit size. A ready sample carries the value of the ready flag. The other four are single-cycle pulses: the sink asked for reauthentication, a DDC read request went out, a DDC transaction completed, or a DDC transaction failed. The register stores each result as a sticky status bit, or as the latest size value. Each event has its own enable and its own acknowledge. One interrupt line is raised while any enabled condition is pending.

Software writes the whole 32-bit word through a single write port and reads it back through a combinational readback port. Only the enable and acknowledge fields can be written. The status bits and the size field change only through events and acknowledges. A write of 1 to an acknowledge bit clears the matching status in the same clock edge that captures the write. An event that arrives in that same cycle takes priority over the clear. The ready interrupt has a two-bit select, so software can wait for ready to read as 1, wait for it to read as 0, or wait for either.

Top module: `rxs_irq_csr`

## Requirements
- R1: After reset the readback word is 0x00000000 and `irq` is 0.
- R2: A write with `wr_en` high loads only the control fields: enables at bits 31, 14, 10, 6 and 2, the ready select at bits 19:18, and acknowledges at bits 30, 17, 13, 9, 5 and 1. Each reads back as written. Status bits, the size field and the reserved bits 11, 7 and 3 are not affected by written data, so writing all ones to a cleared register reads back 0xC00E6666. When `wr_en` is low, `wr_data` has no effect.
- R3: A pulse on `flag_evt[i]` sets a sticky status bit on the next clock edge. Index 0 is DDC request (bit 0), 1 is DDC done (bit 4), 2 is DDC failed (bit 8) and 3 is reauthentication request (bit 12). The bit stays set until it is acknowledged.
- R4: A write that carries 1 in an acknowledge bit clears the status bit one position below it. The acknowledge bits are at 1, 5, 9 and 13. The clear happens on the edge that captures the write. A written 0 leaves the status unchanged.
- R5: If an event and the write that acknowledges it land in the same cycle, the event wins. The status stays set, or the size field takes the new sample.
- R6: A `size_vld` pulse loads `size_val` into bits 29:20, replacing any earlier value. A write of 1 to bit 30 clears the field to zero.
- R7: A `rdy_vld` pulse sets bit 16 when `rdy_bit` is 1 and sets bit 15 when it is 0. Both bits are sticky, and a write of 1 to bit 17 clears both.
- R8: `irq` is the OR of the enabled conditions. A status bit whose enable is 0 never raises `irq`.
- R9: The message-size condition is bit 31 AND a nonzero size field. A zero size never raises `irq`.
- R10: The ready select at bits 19:18 chooses the ready condition. Value 0 gives none, 1 gives bit 16, 2 gives bit 15, and 3 gives either.
- R11: With `IRQ_REG` = 0, `irq` follows the register state in the same cycle as the readback. With `IRQ_REG` = 1 it lags by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register readback |
| flag_evt | input | 4 | Event pulses: 0 request, 1 done, 2 failed, 3 reauth |
| size_vld | input | 1 | Message-size sample strobe |
| size_val | input | SIZE_W | Sampled message size |
| rdy_vld | input | 1 | Ready sample strobe |
| rdy_bit | input | 1 | Sampled ready value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 10-bit size field, and `IRQ_REG` = 0. With the combinational interrupt path, every vector can check the readback and `irq` in the same sampling slot one clock after the stimulus. This exposes the same-cycle priority of event over acknowledge, the zero-size suppression, and all four ready-select codes with no extra latency to track. The registered-interrupt variant is covered only by the assertions local to it.

// File: rtl/rxs_irq_pkg.sv
package rxs_irq_pkg;
   localparam int FIXED_W       = 32;
   localparam int FIXED_SIZE_W  = 10;
   localparam int SIZE_EN_BIT   = 31;
   localparam int SIZE_ACK_BIT  = 30;
   localparam int SIZE_LSB      = 20;
   localparam int RDY_SEL_LSB   = 18;
   localparam int RDY_ACK_BIT   = 17;
   localparam int RDY_ONE_BIT   = 16;
   localparam int RDY_ZERO_BIT  = 15;
   localparam int NFLAG         = 4;
   localparam logic [31:0] CTRL_MASK = 32'hC00E6666;

   typedef enum logic [1:0] {
      RDY_OFF     = 2'd0,
      RDY_ON_ONE  = 2'd1,
      RDY_ON_ZERO = 2'd2,
      RDY_ON_ANY  = 2'd3
   } rdy_sel_e;

   // status position of flag i; ack sits one above, enable two above
   function automatic int flag_st_pos(input int idx);
      case (idx)
         0:       return 0;
         1:       return 4;
         2:       return 8;
         default: return 12;
      endcase
   endfunction
endpackage

// File: rtl/rxs_sticky_bit.sv
module rxs_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/rxs_size_hold.sv
module rxs_size_hold #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= val_i;
      else if (clr_i)  q_o <= '0;
   end

   assert_size_latest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (q_o == $past(val_i)));
   assert_size_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !load_i) |=> (q_o == '0));
endmodule

// File: rtl/rxs_ready_track.sv
module rxs_ready_track (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic bit_i,
   input  logic clr_i,
   output logic one_o,
   output logic zero_o
);
   rxs_sticky_bit u_one (
      .clk(clk), .rst_n(rst_n), .set_i(vld_i && bit_i),
      .clr_i(clr_i), .q_o(one_o));
   rxs_sticky_bit u_zero (
      .clk(clk), .rst_n(rst_n), .set_i(vld_i && !bit_i),
      .clr_i(clr_i), .q_o(zero_o));

   assert_ready_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !bit_i && !zero_o && clr_i) |=> (zero_o && !one_o));
endmodule

// File: rtl/rxs_irq_csr.sv
module rxs_irq_csr
   import rxs_irq_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int SIZE_W  = 10,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [NFLAG-1:0]  flag_evt,
   input  logic              size_vld,
   input  logic [SIZE_W-1:0] size_val,
   input  logic              rdy_vld,
   input  logic              rdy_bit,
   output logic              irq
);
   localparam int SIZE_MSB = SIZE_LSB + SIZE_W - 1;

   generate
      if (REG_W != FIXED_W) begin : g_bad_w
         $error("rxs_irq_csr: REG_W must be %0d", FIXED_W);
      end
      if (SIZE_W != FIXED_SIZE_W) begin : g_bad_size
         $error("rxs_irq_csr: SIZE_W must be %0d", FIXED_SIZE_W);
      end
   endgenerate

   // ---------------- control fields ----------------
   logic             size_en, size_ack, rdy_ack;
   rdy_sel_e         rdy_sel;
   logic [NFLAG-1:0] flag_en, flag_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_en  <= 1'b0;
         size_ack <= 1'b0;
         rdy_ack  <= 1'b0;
         rdy_sel  <= RDY_OFF;
         flag_en  <= '0;
         flag_ack <= '0;
      end else if (wr_en) begin
         size_en  <= wr_data[SIZE_EN_BIT];
         size_ack <= wr_data[SIZE_ACK_BIT];
         rdy_ack  <= wr_data[RDY_ACK_BIT];
         rdy_sel  <= rdy_sel_e'(wr_data[RDY_SEL_LSB +: 2]);
         for (int i = 0; i < NFLAG; i++) begin
            flag_en[i]  <= wr_data[flag_st_pos(i) + 2];
            flag_ack[i] <= wr_data[flag_st_pos(i) + 1];
         end
      end
   end

   // ---------------- status storage ----------------
   logic [NFLAG-1:0]  flag_st;
   logic [SIZE_W-1:0] size_q;
   logic              rdy_one, rdy_zero;

   genvar gi;
   generate
      for (gi = 0; gi < NFLAG; gi++) begin : g_flag
         localparam int ST = flag_st_pos(gi);
         rxs_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_evt[gi]),
            .clr_i (wr_en && wr_data[ST + 1]),
            .q_o   (flag_st[gi])
         );
      end
   endgenerate

   rxs_size_hold #(.W(SIZE_W)) u_size (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (size_vld),
      .val_i  (size_val),
      .clr_i  (wr_en && wr_data[SIZE_ACK_BIT]),
      .q_o    (size_q)
   );

   rxs_ready_track u_rdy (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (rdy_vld),
      .bit_i  (rdy_bit),
      .clr_i  (wr_en && wr_data[RDY_ACK_BIT]),
      .one_o  (rdy_one),
      .zero_o (rdy_zero)
   );

   // ---------------- readback ----------------
   always_comb begin
      rd_data                       = '0;
      rd_data[SIZE_EN_BIT]          = size_en;
      rd_data[SIZE_ACK_BIT]         = size_ack;
      rd_data[SIZE_MSB:SIZE_LSB]    = size_q;
      rd_data[RDY_SEL_LSB +: 2]     = rdy_sel;
      rd_data[RDY_ACK_BIT]          = rdy_ack;
      rd_data[RDY_ONE_BIT]          = rdy_one;
      rd_data[RDY_ZERO_BIT]         = rdy_zero;
      for (int i = 0; i < NFLAG; i++) begin
         rd_data[flag_st_pos(i)]     = flag_st[i];
         rd_data[flag_st_pos(i) + 1] = flag_ack[i];
         rd_data[flag_st_pos(i) + 2] = flag_en[i];
      end
   end

   // ---------------- interrupt ----------------
   logic rdy_term, irq_next;

   always_comb begin
      unique case (rdy_sel)
         RDY_ON_ONE:  rdy_term = rdy_one;
         RDY_ON_ZERO: rdy_term = rdy_zero;
         RDY_ON_ANY:  rdy_term = rdy_one | rdy_zero;
         default:     rdy_term = 1'b0;
      endcase
      irq_next = (|(flag_st & flag_en)) | (size_en & (|size_q)) | rdy_term;
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_next;
         end
         assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
            irq_next |=> irq);
      end else begin : g_irq_comb
         assign irq = irq_next;
         assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[14] == 1'b0 && rd_data[10] == 1'b0 && rd_data[6] == 1'b0 &&
             rd_data[2] == 1'b0 && rd_data[19:18] == 2'd0 && rd_data[31] == 1'b0)
            |-> !irq);
         assert_size_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[29:20] == '0 && rd_data[19:18] == 2'd0 &&
             (rd_data[14:0] & 15'h4444 & {rd_data[12:0], 2'b00}) == '0)
            |-> !irq);
      end
   endgenerate

   // control fields follow the last write
   assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_data & CTRL_MASK) == ($past(wr_data) & CTRL_MASK)));
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[11] == 1'b0) && (rd_data[7] == 1'b0) && (rd_data[3] == 1'b0));
endmodule

// File: tb/rxs_irq_csr_tb_top.sv
module rxs_irq_csr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  flag_evt = '0;
   logic        size_vld = 1'b0;
   logic [9:0]  size_val = '0;
   logic        rdy_vld = 1'b0;
   logic        rdy_bit = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rxs_irq_csr dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .flag_evt(flag_evt), .size_vld(size_vld),
      .size_val(size_val), .rdy_vld(rdy_vld), .rdy_bit(rdy_bit), .irq(irq));

   typedef struct packed {
      logic        wr;
      logic [31:0] wd;
      logic [3:0]  fl;
      logic        sv;
      logic [9:0]  sz;
      logic        rv;
      logic        rb;
      logic [31:0] exp_rd;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 27;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 32'h0,        4'b0001, 1'b0, 10'h0,   1'b0, 1'b0, 32'h00001,    1'b0, 8'd3 },  // R3 req
      '{1'b0, 32'h0,        4'b1110, 1'b0, 10'h0,   1'b0, 1'b0, 32'h01111,    1'b0, 8'd8 },  // R3/R8 unmasked
      '{1'b1, 32'h4,        4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h01115,    1'b1, 8'd8 },  // R8 enable req
      '{1'b1, 32'h6,        4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h01116,    1'b0, 8'd4 },  // R4 ack req
      '{1'b1, 32'h4,        4'b0001, 1'b0, 10'h0,   1'b0, 1'b0, 32'h01115,    1'b1, 8'd3 },  // R3 again
      '{1'b1, 32'h6,        4'b0001, 1'b0, 10'h0,   1'b0, 1'b0, 32'h01117,    1'b1, 8'd5 },  // R5 event wins
      '{1'b1, 32'h0,        4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h01111,    1'b0, 8'd8 },  // R8 masks off
      '{1'b1, 32'h2222,     4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h02222,    1'b0, 8'd4 },  // R4 ack all
      '{1'b1, 32'hFFFFFFFF, 4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'hC00E6666, 1'b0, 8'd2 },  // R2 ctrl only
      '{1'b1, 32'h0,        4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h0,        1'b0, 8'd2 },  // R2
      '{1'b0, 32'h0,        4'b0000, 1'b1, 10'h155, 1'b0, 1'b0, 32'h15500000, 1'b0, 8'd6 },  // R6 load
      '{1'b1, 32'h80000000, 4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h95500000, 1'b1, 8'd9 },  // R9 enable
      '{1'b0, 32'h0,        4'b0000, 1'b1, 10'h3FF, 1'b0, 1'b0, 32'hBFF00000, 1'b1, 8'd6 },  // R6 latest
      '{1'b1, 32'hC0000000, 4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'hC0000000, 1'b0, 8'd6 },  // R6 ack
      '{1'b1, 32'hC0000000, 4'b0000, 1'b1, 10'h007, 1'b0, 1'b0, 32'hC0700000, 1'b1, 8'd5 },  // R5 size wins
      '{1'b0, 32'h0,        4'b0000, 1'b1, 10'h0,   1'b0, 1'b0, 32'hC0000000, 1'b0, 8'd9 },  // R9 zero size
      '{1'b1, 32'h0,        4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h0,        1'b0, 8'd2 },  // R2
      '{1'b0, 32'h0,        4'b0000, 1'b0, 10'h0,   1'b1, 1'b1, 32'h10000,    1'b0, 8'd7 },  // R7 ready 1
      '{1'b1, 32'h40000,    4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h50000,    1'b1, 8'd10},  // R10 sel 1
      '{1'b1, 32'h80000,    4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h90000,    1'b0, 8'd10},  // R10 sel 2
      '{1'b0, 32'h0,        4'b0000, 1'b0, 10'h0,   1'b1, 1'b0, 32'h98000,    1'b1, 8'd7 },  // R7 ready 0
      '{1'b1, 32'hC0000,    4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'hD8000,    1'b1, 8'd10},  // R10 sel 3
      '{1'b1, 32'h0,        4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h18000,    1'b0, 8'd10},  // R10 sel 0
      '{1'b1, 32'h20000,    4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h20000,    1'b0, 8'd7 },  // R7 ack
      '{1'b1, 32'h20000,    4'b0000, 1'b0, 10'h0,   1'b1, 1'b1, 32'h30000,    1'b0, 8'd5 },  // R5 ready wins
      '{1'b1, 32'h4000,     4'b1000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h15000,    1'b1, 8'd11},  // R11 same-cycle irq
      '{1'b0, 32'hFFFFFFFF, 4'b0000, 1'b0, 10'h0,   1'b0, 1'b0, 32'h15000,    1'b1, 8'd2 }   // R2 wr_en low
   };

   task automatic check(input logic [31:0] exp_rd, input logic exp_irq,
                        input int req, input string what);
      checks++;
      if (rd_data !== exp_rd || irq !== exp_irq) begin
         fails++;
         $display("FAIL R%0d %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                  req, what, rd_data, irq, exp_rd, exp_irq);
      end
   endtask

   task automatic apply(input vec_t v);
      wr_en    = v.wr;
      wr_data  = v.wd;
      flag_evt = v.fl;
      size_vld = v.sv;
      size_val = v.sz;
      rdy_vld  = v.rv;
      rdy_bit  = v.rb;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; flag_evt = '0;
      size_vld = 1'b0; size_val = '0; rdy_vld = 1'b0; rdy_bit = 1'b0;
   endtask

   initial begin
      #(8 * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(32'h0, 1'b0, 1, "reset state R1");
      rst_n = 1'b1;
      @(negedge clk);
      check(32'h0, 1'b0, 1, "idle after reset R1");

      for (int k = 0; k < NVEC; k++) begin
         apply(VECS[k]);
         check(VECS[k].exp_rd, VECS[k].exp_irq, int'(VECS[k].req),
               $sformatf("vector %0d", k));
      end

      // directed: R1 reset clears a busy register
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(32'h0, 1'b0, 1, "mid-run reset R1");
      rst_n = 1'b1;

      // directed: R3 status holds across idle cycles, R8 enable raises irq
      flag_evt = 4'b0100;
      @(posedge clk);
      @(negedge clk);
      flag_evt = '0;
      repeat (4) @(negedge clk);
      check(32'h100, 1'b0, 3, "failed status held R3");
      wr_en = 1'b1; wr_data = 32'h400;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      check(32'h500, 1'b1, 8, "failed enable R8");

      // directed: R4 ack written as 0 leaves status
      wr_en = 1'b1; wr_data = 32'h400;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      check(32'h500, 1'b1, 4, "ack zero keeps status R4");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule